// File: doc/BRIEF.md
# Per-Device DMA Window Checker

This block sits on the inbound DMA path and checks every request against a table with one entry per logical device number. Each entry has an enable bit, a window size code, a window base address and two permission bits. A request carries a device number, an address and a direction. The block answers one cycle after it accepts the request, either granting the request or denying it as an access violation.

When a request is denied, the block clears the enable bit of the offending device. It also stores a status word and the faulting address, and sets an interrupt status bit. The captured information stays frozen until software clears it. Requests aimed at devices that are already disabled are still reported. Entries are loaded whole through a write port. Software clears the capture and controls the interrupt through a second small write port.

Top module: `dma_win_check`

## Requirements
- R1: Reset disables every entry. A write on the entry port with `cfg_we` replaces the addressed entry's enable, code, base and permissions. `dev_enabled[i]` shows the enable bit of entry i.
- R2: An enabled entry with code c covers 2^(c+1) bytes. An address hits when it matches the base in every bit at position c+1 or above. A code of ADDR_W-1 or more covers the whole address space.
- R3: Reads need `cfg_rd_ok` and writes need `cfg_wr_ok` to have been set in the entry. A request whose direction is not permitted is denied.
- R4: A request for a disabled entry is always denied.
- R5: `req_ready` equals `!rsp_valid || rsp_ready`. The verdict for a request accepted at one edge appears on `rsp_valid`, `rsp_grant` and `rsp_dev` after that same edge. The verdict holds steady while `rsp_ready` is low.
- R6: A captured violation loads `av_status` as follows: bit 0 is set; bit 1 is the write flag; bit 2 means the entry was disabled; bit 3 means the address missed the window; bit 4 means the permission was missing; the device number sits at bit 16 and up (shift right by 16). The address, zero-extended to 64 bits, goes to `av_addr_hi` and `av_addr_lo`.
- R7: While `av_status` bit 0 is set, further violations are still denied but leave the status and address registers unchanged.
- R8: A status-port write (`sw_sel`=1) with data bit 0 set clears the status and address registers. If a violation arrives in the same cycle, the new violation is captured instead.
- R9: `av_ctl` bit 0 is the interrupt enable and is written from data bit 0 on a control write (`sw_sel`=0). Bit 1 is set by each capture and cleared by a control write with data bit 1. A capture takes priority over that clear. `irq` is high exactly when both bits are set.
- R10: Every denied request clears the enable bit of its device at the same edge, whether or not it is captured. A simultaneous entry write to the same device takes priority.
- R11: A violation on an already disabled device is captured and raises the interrupt like any other violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_dev | input | DEV_W | Entry to write |
| cfg_en | input | 1 | New enable bit |
| cfg_code | input | CODE_W | New window size code |
| cfg_base | input | ADDR_W | New window base |
| cfg_rd_ok | input | 1 | New read permission |
| cfg_wr_ok | input | 1 | New write permission |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_dev | input | DEV_W | Requesting device number |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict consumed |
| rsp_grant | output | 1 | 1 granted, 0 violation |
| rsp_dev | output | DEV_W | Device number of the verdict |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 1 | 0 control register, 1 status register |
| sw_wdata | input | 32 | Software write data |
| av_status | output | 32 | Captured violation status |
| av_addr_hi | output | 32 | Captured address, upper word |
| av_addr_lo | output | 32 | Captured address, lower word |
| av_ctl | output | 32 | Interrupt enable and status bits |
| irq | output | 1 | Violation interrupt |
| dev_enabled | output | 2**DEV_W | Enable bits of all entries |

## Verification
The bench builds the block with DEV_W=3, ADDR_W=40 and CODE_W=6. This makes the table small enough to program entirely. With a 40-bit address, a 64 GiB window (code 35) is a proper sub-window and can be tested against an address one byte past its end. Code 39 then spans the whole space, so both ends of the size encoding can be reached. The 40-bit address also puts nonzero bits into the upper captured word, so the split between the high and low registers is visible.

// File: rtl/dwc_pkg.sv
// Package: field positions and types shared by the DMA window checker.
// Assumes status and control registers are 32 bits wide.
package dwc_pkg;
    localparam int STAT_CAPT_BIT = 0;
    localparam int STAT_WR_BIT   = 1;
    localparam int STAT_OFF_BIT  = 2;
    localparam int STAT_MISS_BIT = 3;
    localparam int STAT_PERM_BIT = 4;
    localparam int STAT_DEV_LSB  = 16;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_ST_BIT    = 1;

    typedef enum logic {SEL_CTL = 1'b0, SEL_STAT = 1'b1} sw_sel_e;

    typedef struct packed {
        logic off;
        logic miss;
        logic perm;
    } cause_t;
endpackage

// File: rtl/dwc_entry_table.sv
// Module: per-device entry storage. Holds enable, size code, base and
// permissions for every device number; written whole by the entry port and
// auto-disabled by the violation path. Assumes an entry write wins over an
// auto-disable of the same entry in the same cycle.
module dwc_entry_table #(
    parameter int DEV_W  = 6,
    parameter int ADDR_W = 64,
    parameter int CODE_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [DEV_W-1:0]      cfg_dev,
    input  logic                  cfg_en,
    input  logic [CODE_W-1:0]     cfg_code,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic                  cfg_rd_ok,
    input  logic                  cfg_wr_ok,
    input  logic                  kill_we,
    input  logic [DEV_W-1:0]      kill_dev,
    input  logic [DEV_W-1:0]      rd_dev,
    output logic                  rd_valid,
    output logic [CODE_W-1:0]     rd_code,
    output logic [ADDR_W-1:0]     rd_base,
    output logic                  rd_rd_ok,
    output logic                  rd_wr_ok,
    output logic [(2**DEV_W)-1:0] valid_vec
);
    localparam int NDEV = 2**DEV_W;

    logic [NDEV-1:0]   en_q;
    logic [NDEV-1:0]   rok_q;
    logic [NDEV-1:0]   wok_q;
    logic [CODE_W-1:0] code_q [NDEV];
    logic [ADDR_W-1:0] base_q [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_ent
        // Entry g: reset, load from the entry port, or auto-disable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]   <= 1'b0;
                rok_q[g]  <= 1'b0;
                wok_q[g]  <= 1'b0;
                code_q[g] <= '0;
                base_q[g] <= '0;
            end else if (cfg_we && cfg_dev == DEV_W'(g)) begin
                en_q[g]   <= cfg_en;
                rok_q[g]  <= cfg_rd_ok;
                wok_q[g]  <= cfg_wr_ok;
                code_q[g] <= cfg_code;
                base_q[g] <= cfg_base;
            end else if (kill_we && kill_dev == DEV_W'(g)) begin
                en_q[g]   <= 1'b0;
            end
        end
    end

    // Read the entry addressed by the current request.
    always_comb begin
        rd_valid = en_q[rd_dev];
        rd_rd_ok = rok_q[rd_dev];
        rd_wr_ok = wok_q[rd_dev];
        rd_code  = code_q[rd_dev];
        rd_base  = base_q[rd_dev];
    end

    assign valid_vec = en_q;

    // R10: a denied request leaves its device disabled unless rewritten.
    assert_kill_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_we && !(cfg_we && cfg_dev == kill_dev)) |=> !valid_vec[$past(kill_dev)]);

    // R1: an entry write lands its enable bit on the next cycle.
    assert_cfg_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> valid_vec[$past(cfg_dev)] == $past(cfg_en));
endmodule

// File: rtl/dwc_judge.sv
// Module: combinational verdict for one request against one entry.
// Assumes the base is aligned to the window; low base bits are ignored.
module dwc_judge
    import dwc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CODE_W = 6
) (
    input  logic              ent_valid,
    input  logic [CODE_W-1:0] ent_code,
    input  logic [ADDR_W-1:0] ent_base,
    input  logic              ent_rd_ok,
    input  logic              ent_wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              grant,
    output cause_t            cause
);
    logic [ADDR_W-1:0] keep;

    // Bit g takes part in the compare only above the window offset.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        assign keep[g] = (32'(g) > 32'(ent_code));
    end

    // Classify the request into disabled, window miss and permission faults.
    always_comb begin
        cause.off  = !ent_valid;
        cause.miss = ent_valid && (|((addr ^ ent_base) & keep));
        cause.perm = ent_valid && (is_write ? !ent_wr_ok : !ent_rd_ok);
        grant      = !(cause.off || cause.miss || cause.perm);
    end
endmodule

// File: rtl/dwc_capture.sv
// Module: violation capture and interrupt. Freezes status and address on
// the first violation until software clears it; a same-cycle violation wins
// over the clear. Assumes ADDR_W <= 64 and DEV_W <= 16.
module dwc_capture
    import dwc_pkg::*;
#(
    parameter int DEV_W  = 6,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_we,
    input  logic [DEV_W-1:0]  viol_dev,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              viol_write,
    input  cause_t            viol_cause,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       status,
    output logic [31:0]       addr_hi,
    output logic [31:0]       addr_lo,
    output logic [31:0]       ctl,
    output logic              irq
);
    logic [31:0] stat_q;
    logic [63:0] addr_q;
    logic        en_q;
    logic        st_q;
    logic        pending;
    logic        stat_clr;
    logic        ctl_wr;
    logic        take;
    logic [31:0] stat_new;
    logic [63:0] addr_ext;
    logic        sw_unused;

    assign sw_unused = ^sw_wdata[31:2];
    assign pending   = stat_q[STAT_CAPT_BIT];
    assign stat_clr  = sw_we && sw_sel_e'(sw_sel) == SEL_STAT && sw_wdata[0];
    assign ctl_wr    = sw_we && sw_sel_e'(sw_sel) == SEL_CTL;
    assign take      = viol_we && (!pending || stat_clr);
    assign addr_ext  = 64'(viol_addr);

    // Assemble the status word for a new capture.
    always_comb begin
        stat_new = '0;
        stat_new[STAT_CAPT_BIT] = 1'b1;
        stat_new[STAT_WR_BIT]   = viol_write;
        stat_new[STAT_OFF_BIT]  = viol_cause.off;
        stat_new[STAT_MISS_BIT] = viol_cause.miss;
        stat_new[STAT_PERM_BIT] = viol_cause.perm;
        stat_new[STAT_DEV_LSB +: DEV_W] = viol_dev;
    end

    // Status and address: capture, clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            addr_q <= '0;
        end else if (take) begin
            stat_q <= stat_new;
            addr_q <= addr_ext;
        end else if (stat_clr) begin
            stat_q <= '0;
            addr_q <= '0;
        end
    end

    // Interrupt enable and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            st_q <= 1'b0;
        end else begin
            if (ctl_wr) en_q <= sw_wdata[CTL_EN_BIT];
            if (take) st_q <= 1'b1;
            else if (ctl_wr && sw_wdata[CTL_ST_BIT]) st_q <= 1'b0;
        end
    end

    // Drive the register views and the interrupt line.
    always_comb begin
        status = stat_q;
        addr_hi = addr_q[63:32];
        addr_lo = addr_q[31:0];
        ctl = '0;
        ctl[CTL_EN_BIT] = en_q;
        ctl[CTL_ST_BIT] = st_q;
        irq = en_q && st_q;
    end

    // R7: a pending capture is frozen unless software clears it.
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !stat_clr) |=> ($stable(stat_q) && $stable(addr_q)));

    // R8: a clear with no competing violation empties the capture.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !viol_we) |=> (stat_q == '0 && addr_q == '0));

    // R9: the interrupt status bit only rises together with a capture.
    assert_st_with_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q) |-> stat_q[STAT_CAPT_BIT]);
endmodule

// File: rtl/dma_win_check.sv
// Module: top of the per-device DMA window checker. Accepts requests on a
// valid/ready port, looks up the device's entry, and registers the verdict
// one cycle after acceptance. Denied requests disable their device and feed
// the capture block. Assumes DEV_W <= 16 and ADDR_W <= 64.
module dma_win_check
    import dwc_pkg::*;
#(
    parameter int DEV_W  = 6,
    parameter int ADDR_W = 64,
    parameter int CODE_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [DEV_W-1:0]      cfg_dev,
    input  logic                  cfg_en,
    input  logic [CODE_W-1:0]     cfg_code,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic                  cfg_rd_ok,
    input  logic                  cfg_wr_ok,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [DEV_W-1:0]      req_dev,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic                  rsp_grant,
    output logic [DEV_W-1:0]      rsp_dev,
    input  logic                  sw_we,
    input  logic                  sw_sel,
    input  logic [31:0]           sw_wdata,
    output logic [31:0]           av_status,
    output logic [31:0]           av_addr_hi,
    output logic [31:0]           av_addr_lo,
    output logic [31:0]           av_ctl,
    output logic                  irq,
    output logic [(2**DEV_W)-1:0] dev_enabled
);
    logic              fire;
    logic              ent_valid;
    logic [CODE_W-1:0] ent_code;
    logic [ADDR_W-1:0] ent_base;
    logic              ent_rd_ok;
    logic              ent_wr_ok;
    logic              verdict;
    cause_t            cause;
    logic              deny;

    assign req_ready = !rsp_valid || rsp_ready;
    assign fire      = req_valid && req_ready;
    assign deny      = fire && !verdict;

    dwc_entry_table #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_en(cfg_en), .cfg_code(cfg_code),
        .cfg_base(cfg_base), .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .kill_we(deny), .kill_dev(req_dev), .rd_dev(req_dev),
        .rd_valid(ent_valid), .rd_code(ent_code), .rd_base(ent_base),
        .rd_rd_ok(ent_rd_ok), .rd_wr_ok(ent_wr_ok), .valid_vec(dev_enabled)
    );

    dwc_judge #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_judge (
        .ent_valid(ent_valid), .ent_code(ent_code), .ent_base(ent_base),
        .ent_rd_ok(ent_rd_ok), .ent_wr_ok(ent_wr_ok),
        .addr(req_addr), .is_write(req_write),
        .grant(verdict), .cause(cause)
    );

    dwc_capture #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .viol_we(deny), .viol_dev(req_dev), .viol_addr(req_addr),
        .viol_write(req_write), .viol_cause(cause),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .status(av_status), .addr_hi(av_addr_hi), .addr_lo(av_addr_lo),
        .ctl(av_ctl), .irq(irq)
    );

    // Response register: load on acceptance, drop when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_dev   <= '0;
        end else if (fire) begin
            rsp_valid <= 1'b1;
            rsp_grant <= verdict;
            rsp_dev   <= req_dev;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R5: a stalled verdict stays put.
    assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant) && $stable(rsp_dev)));

    // R5: every accepted request yields a verdict for its device.
    assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_valid && rsp_dev == $past(req_dev)));

    // R4: a request to a disabled entry is never granted.
    assert_off_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !dev_enabled[req_dev]) |=> !rsp_grant);
endmodule

// File: tb/dma_win_check_bench.sv
// Scoreboard bench: send() pushes the expected verdict, the monitor pops
// and compares it when a verdict is consumed. Inputs change 1 ns after a
// rising edge; outputs are sampled on the falling edge.
module dma_win_check_bench;
    localparam int DEV_W  = 3;
    localparam int ADDR_W = 40;
    localparam int CODE_W = 6;
    localparam int NDEV   = 2**DEV_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_rd_ok = 1'b0, cfg_wr_ok = 1'b0;
    logic [DEV_W-1:0] cfg_dev = '0;
    logic [CODE_W-1:0] cfg_code = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [DEV_W-1:0] req_dev = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_grant, irq;
    logic rsp_ready = 1'b1;
    logic [DEV_W-1:0] rsp_dev;
    logic sw_we = 1'b0, sw_sel = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] av_status, av_addr_hi, av_addr_lo, av_ctl;
    logic [NDEV-1:0] dev_enabled;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DEV_W:0] expq[$];

    always #4 clk = ~clk;

    dma_win_check #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dma_win_check (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_en(cfg_en), .cfg_code(cfg_code),
        .cfg_base(cfg_base), .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_grant(rsp_grant),
        .rsp_dev(rsp_dev), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .av_status(av_status), .av_addr_hi(av_addr_hi), .av_addr_lo(av_addr_lo),
        .av_ctl(av_ctl), .irq(irq), .dev_enabled(dev_enabled)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg(int dev, bit en, int code, logic [ADDR_W-1:0] base, bit rd, bit wr);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_dev = DEV_W'(dev); cfg_en = en; cfg_code = CODE_W'(code);
        cfg_base = base; cfg_rd_ok = rd; cfg_wr_ok = wr;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic swr(bit sel, logic [31:0] data);
        @(posedge clk); #1;
        sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
        @(posedge clk); #1;
        sw_we = 1'b0;
    endtask

    // Drive one request; returns 1 ns after the edge that accepted it.
    task automatic send(int dev, logic [ADDR_W-1:0] addr, bit wr, bit exp_grant);
        @(posedge clk); #1;
        req_valid = 1'b1; req_dev = DEV_W'(dev); req_addr = addr; req_write = wr;
        expq.push_back({exp_grant, DEV_W'(dev)});
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compare each consumed verdict with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                chk("R5 unexpected verdict", 64'(rsp_dev), 64'hFFFF);
            end else begin
                logic [DEV_W:0] e;
                e = expq.pop_front();
                chk("R2/R3/R4 verdict grant", 64'(rsp_grant), 64'(e[DEV_W]));
                chk("R5 verdict device", 64'(rsp_dev), 64'(e[DEV_W-1:0]));
            end
        end
    end

    function automatic logic [31:0] stw(int dev, bit wr, bit off, bit miss, bit perm);
        return 32'(1) | (32'(wr) << 1) | (32'(off) << 2) | (32'(miss) << 3)
             | (32'(perm) << 4) | (32'(dev) << 16);
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 / R5 / R9 reset state
        chk("R1 reset enables", 64'(dev_enabled), 0);
        chk("R5 reset rsp_valid", 64'(rsp_valid), 0);
        chk("R5 reset req_ready", 64'(req_ready), 1);
        chk("R9 reset irq", 64'(irq), 0);
        chk("R6 reset status", 64'(av_status), 0);

        cfg(1, 1, 11, 40'h12_3456_7000, 1, 1);
        cfg(3, 1, 35, 40'h0, 1, 0);
        cfg(4, 1, 39, 40'h0, 1, 1);
        cfg(5, 1, 0, 40'h100, 1, 1);
        @(negedge clk);
        chk("R1 programmed enables", 64'(dev_enabled), 64'h3A);

        // R2 / R3 grants at window edges
        send(1, 40'h12_3456_7000, 0, 1);
        send(1, 40'h12_3456_7FFF, 1, 1);
        send(3, 40'h0F_FFFF_FFFF, 0, 1);
        send(4, 40'hFF_FFFF_FFFF, 1, 1);
        send(5, 40'h101, 1, 1);

        // R2 miss one past the window end; R6 capture; R10 disable
        send(1, 40'h12_3456_8000, 0, 0);
        @(negedge clk);
        chk("R6 status on miss", 64'(av_status), 64'(stw(1, 0, 0, 1, 0)));
        chk("R6 address high", 64'(av_addr_hi), 64'h12);
        chk("R6 address low", 64'(av_addr_lo), 64'h3456_8000);
        chk("R10 device 1 disabled", 64'(dev_enabled), 64'h38);
        chk("R9 status bit without enable", 64'(av_ctl), 64'h2);
        chk("R9 irq masked", 64'(irq), 0);
        swr(0, 32'h1);
        @(negedge clk);
        chk("R9 irq enabled", 64'(irq), 1);

        // R7 pending capture is frozen; R3 write denied; R10 still disables
        send(3, 40'h40, 1, 0);
        @(negedge clk);
        chk("R7 status frozen", 64'(av_status), 64'(stw(1, 0, 0, 1, 0)));
        chk("R7 address frozen", 64'(av_addr_lo), 64'h3456_8000);
        chk("R10 uncaptured disable", 64'(dev_enabled), 64'h30);

        // R8 clear; R9 interrupt status clear
        swr(1, 32'h1);
        @(negedge clk);
        chk("R8 status cleared", 64'(av_status), 0);
        chk("R8 address cleared", 64'(av_addr_hi), 0);
        swr(0, 32'h3);
        @(negedge clk);
        chk("R9 status bit cleared", 64'(av_ctl), 64'h1);
        chk("R9 irq low after clear", 64'(irq), 0);

        // R4 / R11 never-enabled device is reported
        send(2, 40'h0, 0, 0);
        @(negedge clk);
        chk("R11 disabled device captured", 64'(av_status), 64'(stw(2, 0, 1, 0, 0)));
        chk("R11 irq on disabled device", 64'(irq), 1);

        // R8 clear and violation in the same cycle: new capture wins
        fork
            swr(1, 32'h1);
            send(1, 40'h12_3456_7000, 0, 0);
        join
        @(negedge clk);
        chk("R8 same-cycle capture wins", 64'(av_status), 64'(stw(1, 0, 1, 0, 0)));
        chk("R11 auto-disabled device captured", 64'(av_addr_lo), 64'h3456_7000);

        // R3 permission fault captured with write flag
        cfg(3, 1, 35, 40'h0, 1, 0);
        swr(1, 32'h1);
        send(3, 40'h80, 1, 0);
        @(negedge clk);
        chk("R3 permission status", 64'(av_status), 64'(stw(3, 1, 0, 0, 1)));

        // R2 64 GiB window: one byte past is a miss; R2 two-byte window below base
        cfg(3, 1, 35, 40'h0, 1, 1);
        send(3, 40'h10_0000_0000, 0, 0);
        send(5, 40'h0FF, 0, 0);

        // R1 rewrite re-enables an entry
        cfg(1, 1, 11, 40'h12_3456_7000, 1, 1);
        @(negedge clk);
        chk("R1 re-enabled", 64'(dev_enabled[1]), 1);

        // R5 back-pressure
        @(posedge clk); #1 rsp_ready = 1'b0;
        send(4, 40'h5, 0, 1);
        @(negedge clk);
        chk("R5 ready low while stalled", 64'(req_ready), 0);
        chk("R5 verdict present", 64'(rsp_valid), 1);
        @(negedge clk);
        chk("R5 verdict held", 64'({rsp_valid, rsp_grant, rsp_dev}), 64'({1'b1, 1'b1, 3'd4}));
        @(posedge clk); #1 rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", 64'(expq.size()), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule